// File: doc/BRIEF.md
# Endpoint Halt and Data Toggle Controller

This block holds, for every endpoint of a USB device, two pieces of state that the packet engine consults on each transaction: whether the endpoint must answer with a STALL handshake, and which data PID (DATA0 or DATA1) the next data packet on that endpoint should carry. Endpoint 0 is the control endpoint. The remaining endpoints (five by default) carry bulk or interrupt traffic.

Software arms a halt through a masked write port. Writing a zero bit never disarms anything, so a read-modify-write of neighbouring bits cannot change a halt by accident. The control endpoint's halt is released by hardware when a SETUP packet arrives. The other endpoints are released by an explicit software clear. When the auto-release mode is enabled, a decoded Clear Feature (endpoint halt) request naming the endpoint also releases it. Transfer completions advance the data toggle. A mode bit selects whether the toggle of the non-control endpoints advances only on success or on every completion. Token decoding and handshake generation sit outside this block.

Top module: `ep_halt_toggle_ctl`

## Requirements
- R1: A cycle with `halt_wr` high and bit k of `halt_wdata` high makes `halt_o[k]` read 1 from the next cycle on, for every endpoint k.
- R2: A write on `halt_wr` with bit k of `halt_wdata` at 0 leaves `halt_o[k]` unchanged. With no set, clear, SETUP or enabled Clear Feature aimed at an endpoint, its halt state holds.
- R3: `setup_rx` clears `halt_o[0]` on the next cycle. Bit 0 of `halt_clr_mask` has no effect on endpoint 0.
- R4: With `auto_release` at 0, a Clear Feature event leaves the halt of the named endpoint set. A `halt_clr_wr` with mask bit k (k from 1 up) clears `halt_o[k]` on the next cycle.
- R5: With `auto_release` at 1, a Clear Feature event whose `cf_ep` is k (1 up to the last endpoint) clears `halt_o[k]` on the next cycle and no other endpoint's halt.
- R6: If a halt-set for endpoint k coincides with any clear of that endpoint (software clear, SETUP or Clear Feature), `halt_o[k]` is 1 afterwards.
- R7: With `toggle_always` at 0, a completion on endpoint k from 1 up (`xfer_done`, `xfer_ep`=k) inverts `pid_o[k]` only if `xfer_ok` is 1. Encoding: 0 = DATA0, 1 = DATA1.
- R8: With `toggle_always` at 1, a completion on endpoint k from 1 up inverts `pid_o[k]` whatever `xfer_ok` is.
- R9: A Clear Feature event naming endpoint k from 1 up sets `pid_o[k]` to DATA0 (0) in either mode, and it takes priority over a completion in the same cycle. Events naming endpoint 0 or a number at or above `NUM_EP` change nothing.
- R10: `setup_rx` sets `pid_o[0]` to DATA1 (1), taking priority over a completion. An endpoint 0 completion inverts `pid_o[0]` only when `xfer_ok` is 1, in either toggle mode.
- R11: After reset every `halt_o` bit is 0 and every `pid_o` bit is DATA0 (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_release | input | 1 | 1: Clear Feature releases halts of endpoints 1 and up |
| toggle_always | input | 1 | 1: non-control toggles advance on every completion |
| halt_wr | input | 1 | Halt-set write strobe |
| halt_wdata | input | NUM_EP | Bit k = 1 arms the halt of endpoint k |
| halt_clr_wr | input | 1 | Software halt-clear strobe |
| halt_clr_mask | input | NUM_EP | Bit k = 1 clears endpoint k (bit 0 ignored) |
| setup_rx | input | 1 | SETUP packet received on endpoint 0 |
| cf_valid | input | 1 | Clear Feature (endpoint halt) event |
| cf_ep | input | 4 | Endpoint number of the Clear Feature event |
| xfer_done | input | 1 | Transfer completion pulse |
| xfer_ep | input | 4 | Endpoint number of the completion |
| xfer_ok | input | 1 | Completion was successful |
| halt_o | output | NUM_EP | Bit k = 1: endpoint k answers with STALL |
| pid_o | output | NUM_EP | Bit k: data PID for endpoint k, 0 = DATA0, 1 = DATA1 |

## Verification
Every cycle, the embedded assertions check these properties: a set bit arms the halt, an endpoint with no event aimed at it keeps its state, SETUP releases endpoint 0, Clear Feature releases a halt only in auto-release mode, the toggle resets to DATA0 or DATA1, and the toggle inverts or holds according to mode and success. They also check that the event decoder never selects more than one endpoint. Other behaviours only show when several inputs meet in one cycle, and only the bench scenarios exercise those. Examples are a set racing a clear, a Clear Feature racing a completion on the same endpoint, and out-of-range endpoint numbers. The bench also confirms that an event on one endpoint leaves every other endpoint alone.

// File: rtl/ep_ctl_pkg.sv
package ep_ctl_pkg;

  // USB endpoint numbers are four bits wide on the wire
  localparam int unsigned EPNUM_W = 4;
  typedef logic [EPNUM_W-1:0] ep_num_t;

  typedef enum logic {
    PID_DATA0 = 1'b0,
    PID_DATA1 = 1'b1
  } pid_e;

  // true when an event with number num targets endpoint index idx
  function automatic logic ep_match(input logic valid, input ep_num_t num,
                                    input int unsigned idx);
    return valid && (num == ep_num_t'(idx));
  endfunction

  // toggle advance rule for one completion
  function automatic logic pid_advance(input logic cur, input logic ok,
                                       input logic always_adv);
    return (ok || always_adv) ? ~cur : cur;
  endfunction

  // halt next-state: set beats any clear
  function automatic logic halt_next(input logic cur, input logic set,
                                     input logic clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/epc_event_dec.sv
module epc_event_dec
  import ep_ctl_pkg::*;
#(
  parameter int unsigned NUM_EP = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cf_valid,
  input  ep_num_t           cf_ep,
  input  logic              xfer_done,
  input  ep_num_t           xfer_ep,
  output logic [NUM_EP-1:0] cf_hit,
  output logic [NUM_EP-1:0] xfer_hit
);

  // endpoint 0 is never a target of the halt-feature event
  for (genvar k = 0; k < NUM_EP; k++) begin : g_dec
    if (k == 0) begin : g_ctrl
      assign cf_hit[k] = 1'b0;
    end else begin : g_data
      assign cf_hit[k] = ep_match(cf_valid, cf_ep, k);
    end
    assign xfer_hit[k] = ep_match(xfer_done, xfer_ep, k);
  end

  // R5
  cf_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cf_hit));
  // R9
  cf_ep0_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cf_valid && cf_ep == '0 |-> cf_hit == '0);
  // R7
  xfer_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(xfer_hit));

endmodule

// File: rtl/epc_halt_cell.sv
module epc_halt_cell
  import ep_ctl_pkg::*;
#(
  parameter bit IS_CTRL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic setup_rx,
  input  logic cf_hit,
  input  logic auto_release,
  output logic halt_q
);

  logic sw_clr_eff;
  logic hw_clr;
  logic any_clr;

  // control endpoint: only SETUP releases; others: software or feature event
  assign sw_clr_eff = IS_CTRL ? 1'b0 : sw_clr;
  assign hw_clr     = IS_CTRL ? setup_rx : (auto_release & cf_hit);
  assign any_clr    = sw_clr_eff | hw_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= halt_next(halt_q, sw_set, any_clr);
  end

  // R1
  set_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set |=> halt_q);
  // R2
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_set && !sw_clr_eff && !hw_clr |=> $stable(halt_q));

  if (IS_CTRL) begin : g_ctrl_chk
    // R3
    setup_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      setup_rx && !sw_set |=> !halt_q);
    // R3
    ctrl_swclr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q && !setup_rx |=> halt_q);
  end else begin : g_data_chk
    // R5
    cf_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      auto_release && cf_hit && !sw_set |=> !halt_q);
    // R4
    manual_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_release && halt_q && !sw_clr |=> halt_q);
    // R4
    sw_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clr && !sw_set |=> !halt_q);
  end

endmodule

// File: rtl/epc_toggle_cell.sv
module epc_toggle_cell
  import ep_ctl_pkg::*;
#(
  parameter bit IS_CTRL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic setup_rx,
  input  logic cf_hit,
  input  logic xfer_hit,
  input  logic xfer_ok,
  input  logic toggle_always,
  output logic pid_q
);

  logic force_load;
  logic force_val;
  logic adv_mode;

  // control endpoint ignores the toggle mode; SETUP primes DATA1
  assign force_load = IS_CTRL ? setup_rx : cf_hit;
  assign force_val  = IS_CTRL ? PID_DATA1 : PID_DATA0;
  assign adv_mode   = IS_CTRL ? 1'b0 : toggle_always;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pid_q <= PID_DATA0;
    else if (force_load) pid_q <= force_val;
    else if (xfer_hit)   pid_q <= pid_advance(pid_q, xfer_ok, adv_mode);
  end

  if (IS_CTRL) begin : g_ctrl_chk
    // R10
    setup_data1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      setup_rx |=> pid_q == PID_DATA1);
    // R10
    ctrl_fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_hit && !xfer_ok && !setup_rx |=> $stable(pid_q));
  end else begin : g_data_chk
    // R9
    cf_data0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cf_hit |=> pid_q == PID_DATA0);
    // R7
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_hit && !xfer_ok && !toggle_always && !cf_hit |=> $stable(pid_q));
    // R8
    always_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_hit && toggle_always && !cf_hit |=> pid_q != $past(pid_q));
  end

  // R7
  ok_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_hit && xfer_ok && !force_load |=> pid_q != $past(pid_q));
  // R2
  idle_pid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_hit && !force_load |=> $stable(pid_q));

endmodule

// File: rtl/ep_halt_toggle_ctl.sv
module ep_halt_toggle_ctl
  import ep_ctl_pkg::*;
#(
  parameter int unsigned NUM_EP = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_release,
  input  logic              toggle_always,
  input  logic              halt_wr,
  input  logic [NUM_EP-1:0] halt_wdata,
  input  logic              halt_clr_wr,
  input  logic [NUM_EP-1:0] halt_clr_mask,
  input  logic              setup_rx,
  input  logic              cf_valid,
  input  logic [3:0]        cf_ep,
  input  logic              xfer_done,
  input  logic [3:0]        xfer_ep,
  input  logic              xfer_ok,
  output logic [NUM_EP-1:0] halt_o,
  output logic [NUM_EP-1:0] pid_o
);

  localparam int unsigned MAX_EP = 1 << EPNUM_W;

  initial begin
    if (NUM_EP < 2 || NUM_EP > MAX_EP)
      $error("NUM_EP out of range");
  end

  logic [NUM_EP-1:0] sw_set;
  logic [NUM_EP-1:0] sw_clr;
  logic [NUM_EP-1:0] cf_hit;
  logic [NUM_EP-1:0] xfer_hit;

  assign sw_set = halt_wdata    & {NUM_EP{halt_wr}};
  assign sw_clr = halt_clr_mask & {NUM_EP{halt_clr_wr}};

  epc_event_dec #(.NUM_EP(NUM_EP)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cf_valid  (cf_valid),
    .cf_ep     (cf_ep),
    .xfer_done (xfer_done),
    .xfer_ep   (xfer_ep),
    .cf_hit    (cf_hit),
    .xfer_hit  (xfer_hit)
  );

  for (genvar k = 0; k < NUM_EP; k++) begin : g_ep
    localparam bit CTRL = (k == 0);

    epc_halt_cell #(.IS_CTRL(CTRL)) u_halt (
      .clk          (clk),
      .rst_n        (rst_n),
      .sw_set       (sw_set[k]),
      .sw_clr       (sw_clr[k]),
      .setup_rx     (setup_rx),
      .cf_hit       (cf_hit[k]),
      .auto_release (auto_release),
      .halt_q       (halt_o[k])
    );

    epc_toggle_cell #(.IS_CTRL(CTRL)) u_tgl (
      .clk           (clk),
      .rst_n         (rst_n),
      .setup_rx      (setup_rx),
      .cf_hit        (cf_hit[k]),
      .xfer_hit      (xfer_hit[k]),
      .xfer_ok       (xfer_ok),
      .toggle_always (toggle_always),
      .pid_q         (pid_o[k])
    );
  end

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set != '0 |=> (halt_o & $past(sw_set)) == $past(sw_set));
  // R5
  cf_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cf_valid && sw_set == '0 && sw_clr == '0 && !setup_rx
      |=> (halt_o | $past(cf_hit)) == ($past(halt_o) | $past(cf_hit)));

endmodule

// File: tb/tb_ep_halt_toggle_ctl.sv
`timescale 1ns/1ps
module tb_ep_halt_toggle_ctl;

  localparam int N = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_release = 1'b0, toggle_always = 1'b0;
  logic halt_wr = 1'b0, halt_clr_wr = 1'b0, setup_rx = 1'b0;
  logic [N-1:0] halt_wdata = '0, halt_clr_mask = '0;
  logic cf_valid = 1'b0, xfer_done = 1'b0, xfer_ok = 1'b0;
  logic [3:0] cf_ep = '0, xfer_ep = '0;
  logic [N-1:0] halt_o, pid_o;

  int total = 0, bad = 0;
  bit done = 0;
  bit m_halt [N];
  bit m_pid  [N];

  always #2 clk = ~clk;

  ep_halt_toggle_ctl #(.NUM_EP(N)) dut (
    .clk(clk), .rst_n(rst_n), .auto_release(auto_release),
    .toggle_always(toggle_always), .halt_wr(halt_wr), .halt_wdata(halt_wdata),
    .halt_clr_wr(halt_clr_wr), .halt_clr_mask(halt_clr_mask),
    .setup_rx(setup_rx), .cf_valid(cf_valid), .cf_ep(cf_ep),
    .xfer_done(xfer_done), .xfer_ep(xfer_ep), .xfer_ok(xfer_ok),
    .halt_o(halt_o), .pid_o(pid_o)
  );

  task automatic compare(input string tag);
    logic [N-1:0] eh, ep;
    for (int k = 0; k < N; k++) begin
      eh[k] = m_halt[k];
      ep[k] = m_pid[k];
    end
    total += 2;
    if (halt_o !== eh) begin
      bad++;
      $display("FAIL %s halt actual=%b expected=%b", tag, halt_o, eh);
    end
    if (pid_o !== ep) begin
      bad++;
      $display("FAIL %s pid actual=%b expected=%b", tag, pid_o, ep);
    end
  endtask

  // behavioural model of one clock edge, written from the requirements
  task automatic model_edge();
    for (int k = 0; k < N; k++) begin
      bit set, clr, cfk, xk;
      set = halt_wr && halt_wdata[k];
      cfk = cf_valid && (int'(cf_ep) == k) && (k != 0);
      xk  = xfer_done && (int'(xfer_ep) == k);
      if (k == 0) clr = setup_rx;
      else        clr = (halt_clr_wr && halt_clr_mask[k]) || (auto_release && cfk);
      if (set)      m_halt[k] = 1;
      else if (clr) m_halt[k] = 0;
      if (k == 0) begin
        if (setup_rx)          m_pid[k] = 1;
        else if (xk && xfer_ok) m_pid[k] = !m_pid[k];
      end else begin
        if (cfk) m_pid[k] = 0;
        else if (xk && (xfer_ok || toggle_always)) m_pid[k] = !m_pid[k];
      end
    end
  endtask

  task automatic step(input string tag,
                      input logic wr, input logic [N-1:0] wd,
                      input logic cw, input logic [N-1:0] cm,
                      input logic su,
                      input logic cfv, input logic [3:0] cfe,
                      input logic xd, input logic [3:0] xe, input logic xo);
    halt_wr = wr; halt_wdata = wd; halt_clr_wr = cw; halt_clr_mask = cm;
    setup_rx = su; cf_valid = cfv; cf_ep = cfe;
    xfer_done = xd; xfer_ep = xe; xfer_ok = xo;
    @(posedge clk);
    model_edge();
    #1;
    compare(tag);
    halt_wr = 0; halt_wdata = '0; halt_clr_wr = 0; halt_clr_mask = '0;
    setup_rx = 0; cf_valid = 0; cf_ep = '0;
    xfer_done = 0; xfer_ep = '0; xfer_ok = 0;
  endtask

  task automatic idle(input string tag);
    step(tag, 0, '0, 0, '0, 0, 0, 4'd0, 0, 4'd0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) begin m_halt[k] = 0; m_pid[k] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    compare("R11");

    // R1: arm every endpoint
    step("R1", 1, 6'h3F, 0, '0, 0, 0, 4'd0, 0, 4'd0, 0);
    // R2: zero bits in a write do nothing
    step("R2", 1, 6'h00, 0, '0, 0, 0, 4'd0, 0, 4'd0, 0);
    idle("R2");
    // R3: mask bit 0 does not release endpoint 0
    step("R3", 0, '0, 1, 6'h01, 0, 0, 4'd0, 0, 4'd0, 0);
    // R3 / R10: SETUP releases ep0 and primes DATA1
    step("R3", 0, '0, 0, '0, 1, 0, 4'd0, 0, 4'd0, 0);
    // R4: manual mode, feature event keeps halt, resets pid
    auto_release = 0;
    step("R4", 0, '0, 0, '0, 0, 1, 4'd2, 0, 4'd0, 0);
    step("R4", 0, '0, 1, 6'h04, 0, 0, 4'd0, 0, 4'd0, 0);
    // R5: auto mode releases only the named endpoint
    auto_release = 1;
    step("R5", 0, '0, 0, '0, 0, 1, 4'd3, 0, 4'd0, 0);
    // R9: out-of-range and ep0 events ignored
    step("R9", 0, '0, 0, '0, 0, 1, 4'd9, 0, 4'd9, 1);
    step("R9", 0, '0, 0, '0, 0, 1, 4'd0, 0, 4'd0, 0);
    // R6: set races feature clear, software clear, SETUP
    step("R6", 1, 6'h02, 0, '0, 0, 1, 4'd1, 0, 4'd0, 0);
    step("R6", 1, 6'h08, 1, 6'h08, 0, 0, 4'd0, 0, 4'd0, 0);
    step("R6", 1, 6'h01, 0, '0, 1, 0, 4'd0, 0, 4'd0, 0);
    // R7: success-only toggling
    toggle_always = 0;
    step("R7", 0, '0, 0, '0, 0, 0, 4'd0, 1, 4'd4, 0);
    step("R7", 0, '0, 0, '0, 0, 0, 4'd0, 1, 4'd4, 1);
    step("R7", 0, '0, 0, '0, 0, 0, 4'd0, 1, 4'd5, 1);
    // R8: toggle on every completion
    toggle_always = 1;
    step("R8", 0, '0, 0, '0, 0, 0, 4'd0, 1, 4'd4, 0);
    step("R8", 0, '0, 0, '0, 0, 0, 4'd0, 1, 4'd1, 0);
    // R9: feature event beats completion on the same endpoint
    step("R9", 0, '0, 0, '0, 0, 1, 4'd5, 1, 4'd5, 1);
    // R10: ep0 ignores toggle mode, SETUP beats completion
    step("R10", 0, '0, 0, '0, 0, 0, 4'd0, 1, 4'd0, 0);
    step("R10", 0, '0, 0, '0, 0, 0, 4'd0, 1, 4'd0, 1);
    step("R10", 0, '0, 0, '0, 1, 0, 4'd0, 1, 4'd0, 1);

    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      auto_release  = 1'($urandom_range(0, 1));
      toggle_always = 1'($urandom_range(0, 1));
      step("MIX", 1'($urandom_range(0, 3) == 0), N'($urandom),
           1'($urandom_range(0, 3) == 0), N'($urandom),
           1'($urandom_range(0, 7) == 0),
           1'($urandom_range(0, 3) == 0), 4'($urandom_range(0, 7)),
           1'($urandom_range(0, 1)), 4'($urandom_range(0, 7)),
           1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule